// File: doc/BRIEF.md
# Trigger Select and Edge Event Detector

This block feeds the five control functions of a timer/counter channel: capture, count, reload, stop and start. For each function it picks one source out of sixteen, either one of fourteen external trigger lines or one of two built-in constants. It then turns the chosen level into a one-cycle event strobe under a per-function edge mode. External lines are first brought into the clock domain by a two-flop synchronizer. A software command input for each function sets a pending bit. That bit raises the function's event once and then clears itself, so firmware can fire any function without an external trigger.

Each function has its own small state machine with three named states. CH_IDLE is the disabled state. CH_PRIME lasts one cycle: it loads the edge history and suppresses events. CH_ARMED is the state in which events are produced. The transitions are:

- `enable` moves a channel from CH_IDLE to CH_PRIME.
- `settle` moves it from CH_PRIME to CH_ARMED.
- `hold` keeps it in CH_ARMED while the enable input stays high.
- `drop` sends any state back to CH_IDLE as soon as the enable input falls.

Select fields and edge fields are packed by function index: 0 capture, 1 count, 2 reload, 3 stop, 4 start. Function k uses bits [4k+3:4k] of the select bus and bits [2k+1:2k] of the edge bus.

Top module: `trig_event_unit`

## Requirements
- R1: Select value 0 is a constant low source. In every edge mode, a function selecting it never produces a hardware event.
- R2: Select value 1 is a constant high source. In level mode (edge code 3), a function selecting it produces an event in every cycle once armed.
- R3: Select value s, for s from 2 to 15, picks external line s-2. That line passes through two synchronizer flops, so an event caused by a change on it appears on the third rising clock edge after the change.
- R4: Edge code 0 (rising) gives exactly one event cycle when the synchronized source goes from 0 to 1, and none when it goes from 1 to 0.
- R5: Edge code 1 (falling) gives exactly one event cycle when the synchronized source goes from 1 to 0, and none when it goes from 0 to 1.
- R6: Edge code 2 (both) gives one event cycle whenever the sampled source differs from its previous sample. An even number of edges between two clock edges leaves the sample unchanged and gives no event.
- R7: Edge code 3 (level) passes the synchronized source through: the event output is high exactly while the source is high, with the same three-edge latency.
- R8: A one-cycle pulse on a function's software command input sets its pending output on the next clock edge. When the channel is armed, the event output rises on the edge after that and the pending output clears on that same edge.
- R9: While the enable input is low, all event outputs and pending outputs are forced low one edge later, and software command pulses are ignored.
- R10: After the enable input rises, no event comes from the edge history during the CH_IDLE and CH_PRIME cycles. A source that is already high when the block is enabled therefore produces no rising or both-edges event.
- R11: The five functions are independent. Each uses its own select and edge fields, and an event on one function leaves the event outputs of the others low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Block enable; low clears history, events and pending commands |
| ext_trig_i | input | 14 | Asynchronous external trigger lines |
| sel_i | input | 20 | Five 4-bit source selects, function k at [4k+3:4k] |
| edge_i | input | 10 | Five 2-bit edge modes (0 rise, 1 fall, 2 both, 3 level), function k at [2k+1:2k] |
| cmd_set_i | input | 5 | Software command pulses, one per function |
| evt_o | output | 5 | One-cycle event strobes, one per function |
| cmd_pend_o | output | 5 | Self-clearing pending software command bits |

## Verification
An external line change driven between clock edges reaches the event output on the third rising edge: one edge for each synchronizer flop and one for the registered event. The bench therefore waits exactly three rising edges and samples on the next falling edge, then samples once more a cycle later to show that the strobe has ended. A software command shows on the pending output after one edge and on the event output after two. Enable and disable effects show after one edge, and the directed tests sample at exactly those falling edges. Before each stimulus the bench waits for the channel to be armed, so the priming cycles never overlap a check.

// File: rtl/trig_evt_pkg.sv
package trig_evt_pkg;

    typedef enum logic [1:0] {
        EDGE_RISE  = 2'd0,
        EDGE_FALL  = 2'd1,
        EDGE_BOTH  = 2'd2,
        EDGE_LEVEL = 2'd3
    } edge_mode_e;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_PRIME = 2'd1,
        CH_ARMED = 2'd2
    } ch_state_e;

    localparam int MODE_W = 2;

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int WIDTH = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/trig_sel_mux.sv
module trig_sel_mux #(
    parameter int NUM_EXT = 14,
    localparam int NUM_SRC = NUM_EXT + 2,
    localparam int SEL_W = $clog2(NUM_SRC)
) (
    input  logic [NUM_EXT-1:0] ext_sync_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               src_o
);

    logic [NUM_SRC-1:0] src_vec;

    // index 0 tied low, index 1 tied high, externals from index 2 upward
    assign src_vec = {ext_sync_i, 1'b1, 1'b0};

    always_comb begin
        src_o = 1'b0;
        if (int'(sel_i) < NUM_SRC) begin
            src_o = src_vec[sel_i];
        end
    end

endmodule

// File: rtl/edge_chan.sv
module edge_chan
    import trig_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              src_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              cmd_set_i,
    output logic              evt_o,
    output logic              pend_o
);

    ch_state_e  state_q;
    ch_state_e  state_d;
    edge_mode_e mode;
    logic       prev_q;
    logic       hw_hit;
    logic       armed;

    assign mode  = edge_mode_e'(mode_i);
    assign armed = (state_q == CH_ARMED);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: enable, settle, hold, drop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:  state_d = en_i ? CH_PRIME : CH_IDLE;
            CH_PRIME: state_d = en_i ? CH_ARMED : CH_IDLE;
            CH_ARMED: state_d = en_i ? CH_ARMED : CH_IDLE;
            default:  state_d = CH_IDLE;
        endcase
    end

    always_comb begin
        hw_hit = 1'b0;
        unique case (mode)
            EDGE_RISE:  hw_hit = src_i & ~prev_q;
            EDGE_FALL:  hw_hit = ~src_i & prev_q;
            EDGE_BOTH:  hw_hit = src_i ^ prev_q;
            EDGE_LEVEL: hw_hit = src_i;
            default:    hw_hit = 1'b0;
        endcase
    end

    // outputs and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            evt_o  <= 1'b0;
            pend_o <= 1'b0;
        end else if (!en_i) begin
            prev_q <= 1'b0;
            evt_o  <= 1'b0;
            pend_o <= 1'b0;
        end else begin
            prev_q <= src_i;
            evt_o  <= armed && (hw_hit || pend_o);
            pend_o <= (pend_o && !armed) || cmd_set_i;
        end
    end

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!evt_o && !pend_o));

    // R10
    prime_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_PRIME) |=> !evt_o);

    // R8
    cmd_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && armed && en_i) |=> evt_o);

    // R8
    cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && armed && en_i && !cmd_set_i) |=> !pend_o);

    // R4
    rise_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && en_i && mode == EDGE_RISE && !src_i && !pend_o) |=> !evt_o);

    // R7
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && en_i && mode == EDGE_LEVEL && src_i) |=> evt_o);

endmodule

// File: rtl/trig_event_unit.sv
module trig_event_unit
    import trig_evt_pkg::*;
#(
    parameter int NUM_EXT = 14,
    parameter int NUM_FN  = 5,
    localparam int SEL_W  = $clog2(NUM_EXT + 2)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en_i,
    input  logic [NUM_EXT-1:0]        ext_trig_i,
    input  logic [NUM_FN*SEL_W-1:0]   sel_i,
    input  logic [NUM_FN*MODE_W-1:0]  edge_i,
    input  logic [NUM_FN-1:0]         cmd_set_i,
    output logic [NUM_FN-1:0]         evt_o,
    output logic [NUM_FN-1:0]         cmd_pend_o
);

    logic [NUM_EXT-1:0] ext_sync;
    logic [NUM_FN-1:0]  fn_src;

    trig_sync #(.WIDTH(NUM_EXT)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_trig_i),
        .sync_o  (ext_sync)
    );

    for (genvar k = 0; k < NUM_FN; k++) begin : g_fn
        trig_sel_mux #(.NUM_EXT(NUM_EXT)) u_mux (
            .ext_sync_i (ext_sync),
            .sel_i      (sel_i[k*SEL_W +: SEL_W]),
            .src_o      (fn_src[k])
        );

        edge_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (en_i),
            .src_i     (fn_src[k]),
            .mode_i    (edge_i[k*MODE_W +: MODE_W]),
            .cmd_set_i (cmd_set_i[k]),
            .evt_o     (evt_o[k]),
            .pend_o    (cmd_pend_o[k])
        );
    end

endmodule

// File: tb/tb_trig_event_unit.sv
`timescale 1ns/1ps
module tb_trig_event_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [13:0] ext = '0;
    logic [19:0] sel_r = '0;
    logic [9:0]  edge_r = '1;
    logic [4:0]  cmd = '0;
    logic [4:0]  evt_o;
    logic [4:0]  cmd_pend_o;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    trig_event_unit dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .ext_trig_i (ext),
        .sel_i      (sel_r),
        .edge_i     (edge_r),
        .cmd_set_i  (cmd),
        .evt_o      (evt_o),
        .cmd_pend_o (cmd_pend_o)
    );

    task automatic chk(input string req, input logic [4:0] got, input logic [4:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // {sel[3:0], mode[1:0], pre, post, exp_before, exp_hit, exp_after}
    localparam logic [10:0] VEC [12] = '{
        {4'd2,  2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        {4'd5,  2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {4'd15, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        {4'd7,  2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'd3,  2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        {4'd9,  2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        {4'd4,  2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        {4'd11, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {4'd0,  2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'd1,  2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        {4'd1,  2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'd0,  2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    function automatic string tag_of(input logic [3:0] s, input logic [1:0] m);
        if (s == 4'd0) return "R1";
        if (s == 4'd1) return (m == 2'd3) ? "R2" : "R10";
        case (m)
            2'd0:    return "R3/R4";
            2'd1:    return "R3/R5";
            2'd2:    return "R3/R6";
            default: return "R3/R7";
        endcase
    endfunction

    initial begin
        #4_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 reset evt", evt_o, 5'b0);
        chk("R9 reset pend", cmd_pend_o, 5'b0);
        rst_n = 1'b1;

        for (int i = 0; i < 12; i++) begin
            logic [10:0] v;
            logic [13:0] oh;
            int ch;
            string tg;
            v  = VEC[i];
            ch = i % 5;
            tg = tag_of(v[10:7], v[6:5]);
            @(negedge clk);
            en = 1'b0;
            sel_r = '0;
            edge_r = '1;
            sel_r[ch*4 +: 4]  = v[10:7];
            edge_r[ch*2 +: 2] = v[6:5];
            oh  = (v[10:7] >= 4'd2) ? (14'd1 << (v[10:7] - 4'd2)) : 14'd0;
            ext = v[4] ? oh : ~oh;
            repeat (6) @(negedge clk);
            en = 1'b1;
            repeat (6) @(negedge clk);
            chk({tg, " before"}, {4'b0, evt_o[ch]}, {4'b0, v[2]});
            ext = v[3] ? oh : ~oh;
            repeat (3) @(posedge clk);
            @(negedge clk);
            chk({tg, " hit"}, {4'b0, evt_o[ch]}, {4'b0, v[1]});
            chk("R11 others quiet", evt_o & ~(5'b1 << ch), 5'b0);
            @(negedge clk);
            chk({tg, " after"}, {4'b0, evt_o[ch]}, {4'b0, v[0]});
        end

        // R8 software command on function 2
        @(negedge clk);
        en = 1'b0;
        sel_r = '0;
        edge_r = '1;
        ext = '0;
        repeat (2) @(negedge clk);
        en = 1'b1;
        repeat (4) @(negedge clk);
        cmd = 5'b00100;
        @(negedge clk);
        cmd = 5'b0;
        chk("R8 pend set", cmd_pend_o, 5'b00100);
        chk("R8 no evt yet", evt_o, 5'b0);
        @(negedge clk);
        chk("R8 evt", evt_o, 5'b00100);
        chk("R8 pend cleared", cmd_pend_o, 5'b0);
        @(negedge clk);
        chk("R8 evt ends", evt_o, 5'b0);

        // R9 disable clears pending, commands ignored while disabled
        cmd = 5'b10000;
        @(negedge clk);
        cmd = 5'b0;
        en = 1'b0;
        @(negedge clk);
        chk("R9 pend cleared", cmd_pend_o, 5'b0);
        chk("R9 evt low", evt_o, 5'b0);
        cmd = 5'b11111;
        @(negedge clk);
        cmd = 5'b0;
        chk("R9 cmd ignored", cmd_pend_o, 5'b0);
        @(negedge clk);
        chk("R9 no evt", evt_o, 5'b0);

        // R6 two edges within one period cancel
        sel_r[3:0] = 4'd2;
        edge_r[1:0] = 2'd2;
        ext = '0;
        en = 1'b1;
        repeat (6) @(negedge clk);
        ext[0] = 1'b1;
        #3 ext[0] = 1'b0;
        begin
            int cnt;
            cnt = 0;
            for (int j = 0; j < 6; j++) begin
                @(negedge clk);
                if (evt_o[0]) cnt++;
            end
            chk("R6 even edges cancel", cnt[4:0], 5'd0);
        end

        // R10 source already high when enabled: no rising event
        @(negedge clk);
        en = 1'b0;
        edge_r[1:0] = 2'd0;
        ext[0] = 1'b1;
        repeat (4) @(negedge clk);
        en = 1'b1;
        begin
            int cnt;
            cnt = 0;
            for (int j = 0; j < 6; j++) begin
                @(negedge clk);
                if (evt_o[0]) cnt++;
            end
            chk("R10 no false edge", cnt[4:0], 5'd0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule